// File: doc/BRIEF.md
# Single-Wire Battery-Monitor Bus Master

This block masters a single-wire, open-drain bus to a battery-monitor device. It carries out one transaction per host request. A transaction opens with a long low reset pulse. A command byte follows, with a 7-bit register address in bits 6..0 and a direction flag in bit 7. A write then carries one data byte out. A read takes one data byte back by timing how long the device holds the line low in each bit cell. All timing is built from a 20 µs sample tick, divided down from the system clock. The tick counter runs only while a transaction is in progress, so every transaction starts on a fresh tick phase.

The host starts a transaction by making its request counter differ from the block's completion counter. The block latches the command and transmit byte at that point. When the transaction ends, with or without success, the completion counter steps by one and a 2-bit result code is updated. The pad side has two signals. One is an output enable that pulls the wire low when high. The other is the line level, which passes through a two-flop synchronizer and is looked at only on ticks.

Top module: `hdq_master`

## Requirements
- R1: Every timed interval on the line is a whole number of ticks of CLK_PER_TICK clock cycles. The tick phase restarts at each transaction start, so the first tick falls CLK_PER_TICK cycles after the start.
- R2: When req_cnt differs from done_cnt in idle, a transaction starts and line_oe rises on the next clock edge. At its end, done_cnt increases by exactly one.
- R3: A transaction opens with line_oe high for 10 ticks (the reset pulse), then low for 3 ticks before the first bit.
- R4: Bytes go out least significant bit first in cells of 10 ticks each. A 1 is driven low for 2 ticks and a 0 for 6 ticks. The line is released for the rest of each cell.
- R5: Command bit 7 set selects a write and bit 7 clear selects a read. The values of cmd and tx_data at the start are used for the whole transaction.
- R6: On a write, the line stays released for 15 more ticks after the last command cell. The data byte then goes out with the R4 encoding, and the transaction ends with err_code 0.
- R7: On a read, line_oe stays low from the end of the command until completion. If no low level is sampled within 150 ticks, the transaction ends with err_code 1.
- R8: On a read, the number of consecutive ticks at which the line is sampled low is measured for each bit. A count of 3 or fewer decodes as 1, and a larger count as 0. The first received bit lands in rx_data bit 0. After 8 bits, rx_data updates and err_code is 0.
- R9: If a received low phase lasts past its limit, the transaction ends with err_code 2. The limit is 15 ticks for the first bit and 20 ticks for later bits.
- R10: If the line stays high for more than 50 ticks between two received bits, the transaction ends with err_code 3.
- R11: In idle, line_oe is low. rx_data changes only on a read that completes with err_code 0 and keeps its value after any error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_cnt | input | 8 | Host request counter; a difference from done_cnt requests a transaction |
| cmd | input | 8 | Command byte: bit 7 write flag, bits 6..0 register address |
| tx_data | input | 8 | Byte sent in a write |
| done_cnt | output | 8 | Completion counter, steps once per finished transaction |
| rx_data | output | 8 | Byte received by the last successful read |
| err_code | output | 2 | Result: 0 ok, 1 no response, 2 low too long, 3 high too long |
| line_oe | output | 1 | High pulls the wire low; low releases it |
| line_in | input | 1 | Wire level from the pad |

## Verification
The bench decodes every outgoing pulse from line_oe and checks each cell's low and high widths to the cycle. A wrong break length or bit encoding, MSB-first shifting, or a missing write gap would each show up as a wrong width or a wrong decoded byte. The device model answers reads with randomized low and high widths close to the decode threshold, including single-tick pulses. A decoder that missed short pulses, used the wrong threshold, or shifted from the wrong end would return a different byte. Each of the four result codes is provoked, including a low-phase timeout on a later bit. A design that overwrote rx_data on error, drove the wire while receiving, or skipped a completion-count step would then report stale or wrong values.

// File: rtl/hdq_pkg.sv
package hdq_pkg;
    localparam int TICK_US    = 20;
    localparam int BREAK_US   = 210;
    localparam int RECOV_US   = 60;
    localparam int ONE_US     = 50;
    localparam int ZERO_US    = 120;
    localparam int CELL_US    = 210;
    localparam int GAP_US     = 300;
    localparam int RXWAIT_US  = 3000;
    localparam int RXLOW1_US  = 300;
    localparam int RXLOWN_US  = 400;
    localparam int RXHIGH_US  = 1000;
    localparam int THR_US     = 65;

    localparam int BREAK_T  = BREAK_US / TICK_US;
    localparam int RECOV_T  = RECOV_US / TICK_US;
    localparam int ONE_T    = ONE_US / TICK_US;
    localparam int ZERO_T   = ZERO_US / TICK_US;
    localparam int CELL_T   = CELL_US / TICK_US;
    localparam int GAP_T    = GAP_US / TICK_US;
    localparam int RXWAIT_T = RXWAIT_US / TICK_US;
    localparam int RXLOW1_T = RXLOW1_US / TICK_US;
    localparam int RXLOWN_T = RXLOWN_US / TICK_US;
    localparam int RXHIGH_T = RXHIGH_US / TICK_US;
    localparam int THR_T    = THR_US / TICK_US;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(RXWAIT_T + 1);
    localparam int BIT_W  = $clog2(BYTE_W + 1);

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [BIT_W-1:0]  bitn_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BREAK,
        ST_RECOV,
        ST_TX_LOW,
        ST_TX_HIGH,
        ST_GAP,
        ST_RX_WAIT,
        ST_RX_LOW,
        ST_RX_HIGH
    } state_t;

    typedef struct packed {
        state_t     state;
        cnt_t       cnt;
        cnt_t       lowcnt;
        bitn_t      bitcnt;
        byte_t      shreg;
        byte_t      cmd;
        byte_t      txd;
        logic       data_ph;
        logic       oe;
        byte_t      done;
        byte_t      rx;
        logic [1:0] err;
    } regs_t;
endpackage

// File: rtl/hdq_tick_gen.sv
module hdq_tick_gen #(
    parameter int DIV = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!en) begin
            cnt_d = '0;
        end else if (cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    generate
        if (DIV > 1) begin : g_spacing
            // ticks are never adjacent when the divider exceeds one
            assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/hdq_sync.sv
module hdq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] ff_d, ff_q;

    always_comb begin
        ff_d = {ff_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ff_q <= '1;
        end else begin
            ff_q <= ff_d;
        end
    end

    assign sync_o = ff_q[STAGES-1];
endmodule

// File: rtl/hdq_master.sv
module hdq_master
    import hdq_pkg::*;
#(
    parameter int CLK_PER_TICK = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] req_cnt,
    input  logic [7:0] cmd,
    input  logic [7:0] tx_data,
    output logic [7:0] done_cnt,
    output logic [7:0] rx_data,
    output logic [1:0] err_code,
    output logic       line_oe,
    input  logic       line_in
);
    regs_t r_d, r_q;
    logic  tick;
    logic  line_s;
    logic  tick_en;
    byte_t rx_next;

    assign tick_en = (r_q.state != ST_IDLE);

    hdq_tick_gen #(.DIV(CLK_PER_TICK)) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (tick_en),
        .tick  (tick)
    );

    hdq_sync #(.STAGES(2)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (line_in),
        .sync_o  (line_s)
    );

    function automatic cnt_t low_len(input logic b);
        return b ? cnt_t'(ONE_T) : cnt_t'(ZERO_T);
    endfunction

    always_comb begin
        r_d     = r_q;
        rx_next = {(r_q.lowcnt <= cnt_t'(THR_T)), r_q.shreg[BYTE_W-1:1]};
        case (r_q.state)
            ST_IDLE: begin
                r_d.oe = 1'b0;
                if (req_cnt != r_q.done) begin
                    r_d.state = ST_BREAK;
                    r_d.oe    = 1'b1;
                    r_d.cnt   = cnt_t'(BREAK_T);
                    r_d.cmd   = cmd;
                    r_d.txd   = tx_data;
                end
            end
            ST_BREAK: if (tick) begin
                if (r_q.cnt == cnt_t'(1)) begin
                    r_d.state = ST_RECOV;
                    r_d.oe    = 1'b0;
                    r_d.cnt   = cnt_t'(RECOV_T);
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_RECOV: if (tick) begin
                if (r_q.cnt == cnt_t'(1)) begin
                    r_d.state   = ST_TX_LOW;
                    r_d.oe      = 1'b1;
                    r_d.shreg   = r_q.cmd;
                    r_d.bitcnt  = bitn_t'(BYTE_W);
                    r_d.data_ph = 1'b0;
                    r_d.cnt     = low_len(r_q.cmd[0]);
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_TX_LOW: if (tick) begin
                if (r_q.cnt == cnt_t'(1)) begin
                    r_d.state  = ST_TX_HIGH;
                    r_d.oe     = 1'b0;
                    r_d.cnt    = cnt_t'(CELL_T) - low_len(r_q.shreg[0]);
                    r_d.shreg  = {1'b0, r_q.shreg[BYTE_W-1:1]};
                    r_d.bitcnt = r_q.bitcnt - 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_TX_HIGH: if (tick) begin
                if (r_q.cnt != cnt_t'(1)) begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end else if (r_q.bitcnt != '0) begin
                    r_d.state = ST_TX_LOW;
                    r_d.oe    = 1'b1;
                    r_d.cnt   = low_len(r_q.shreg[0]);
                end else if (r_q.data_ph) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = r_q.done + 1'b1;
                    r_d.err   = 2'd0;
                end else if (r_q.cmd[BYTE_W-1]) begin
                    r_d.state = ST_GAP;
                    r_d.cnt   = cnt_t'(GAP_T);
                end else begin
                    r_d.state = ST_RX_WAIT;
                    r_d.cnt   = cnt_t'(RXWAIT_T);
                end
            end
            ST_GAP: if (tick) begin
                if (r_q.cnt == cnt_t'(1)) begin
                    r_d.state   = ST_TX_LOW;
                    r_d.oe      = 1'b1;
                    r_d.shreg   = r_q.txd;
                    r_d.bitcnt  = bitn_t'(BYTE_W);
                    r_d.data_ph = 1'b1;
                    r_d.cnt     = low_len(r_q.txd[0]);
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_RX_WAIT: if (tick) begin
                if (!line_s) begin
                    r_d.state  = ST_RX_LOW;
                    r_d.cnt    = cnt_t'(RXLOW1_T);
                    r_d.lowcnt = cnt_t'(1);
                    r_d.bitcnt = bitn_t'(BYTE_W);
                end else if (r_q.cnt == cnt_t'(1)) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = r_q.done + 1'b1;
                    r_d.err   = 2'd1;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_RX_LOW: if (tick) begin
                if (line_s) begin
                    r_d.shreg  = rx_next;
                    r_d.bitcnt = r_q.bitcnt - 1'b1;
                    if (r_q.bitcnt == bitn_t'(1)) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = r_q.done + 1'b1;
                        r_d.err   = 2'd0;
                        r_d.rx    = rx_next;
                    end else begin
                        r_d.state = ST_RX_HIGH;
                        r_d.cnt   = cnt_t'(RXHIGH_T);
                    end
                end else if (r_q.cnt == cnt_t'(1)) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = r_q.done + 1'b1;
                    r_d.err   = 2'd2;
                end else begin
                    r_d.cnt    = r_q.cnt - 1'b1;
                    r_d.lowcnt = r_q.lowcnt + 1'b1;
                end
            end
            ST_RX_HIGH: if (tick) begin
                if (!line_s) begin
                    r_d.state  = ST_RX_LOW;
                    r_d.cnt    = cnt_t'(RXLOWN_T);
                    r_d.lowcnt = cnt_t'(1);
                end else if (r_q.cnt == cnt_t'(1)) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = r_q.done + 1'b1;
                    r_d.err   = 2'd3;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            default: begin
                r_d.state = ST_IDLE;
                r_d.oe    = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign done_cnt = r_q.done;
    assign rx_data  = r_q.rx;
    assign err_code = r_q.err;
    assign line_oe  = r_q.oe;

    assert_done_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.done != $past(r_q.done)) |-> (r_q.done == $past(r_q.done) + 8'd1));

    assert_idle_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE) |-> !line_oe);

    assert_rx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> (err_code == 2'd0 && done_cnt != $past(done_cnt)));

    assert_rx_no_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_RX_WAIT || r_q.state == ST_RX_LOW || r_q.state == ST_RX_HIGH)
            |-> !line_oe);

    assert_bitcnt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.bitcnt <= bitn_t'(BYTE_W));
endmodule

// File: tb/hdq_master_tb.sv
module hdq_master_tb_top;
    localparam int CPT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req = 8'd0;
    logic [7:0] cmd = 8'd0;
    logic [7:0] txd = 8'd0;
    logic [7:0] done_cnt, rx_data;
    logic [1:0] err_code;
    logic       line_oe;
    logic       pull = 1'b0;
    logic       line_in;
    logic       dev_active = 1'b0;
    logic       oe_bad = 1'b0;
    logic [7:0] last_rx = 8'd0;
    int         checks = 0;
    int         errors = 0;

    assign line_in = ~(line_oe | pull);

    always #5 clk = ~clk;

    hdq_master #(.CLK_PER_TICK(CPT)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_cnt  (req),
        .cmd      (cmd),
        .tx_data  (txd),
        .done_cnt (done_cnt),
        .rx_data  (rx_data),
        .err_code (err_code),
        .line_oe  (line_oe),
        .line_in  (line_in)
    );

    always @(negedge clk) if (dev_active && line_oe) oe_bad <= 1'b1;

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    // high cycles before the next line_oe pulse, then its low width in cycles
    task automatic get_pulse(input int hb0, output int hb, output int lo);
        hb = hb0;
        forever begin
            @(negedge clk);
            if (line_oe) break;
            hb++;
        end
        lo = 1;
        forever begin
            @(negedge clk);
            if (!line_oe) break;
            lo++;
        end
    endtask

    function automatic int cell_low(input logic b);
        return b ? 2 * CPT : 6 * CPT;
    endfunction

    // decode a byte from the master; first_hb is the expected high time before bit 0
    task automatic take_byte(input logic [7:0] exp, input int first_hb, output int last_lo,
                             input string tag);
        logic [7:0] got = 8'd0;
        logic timing_ok = 1'b1;
        int hb, lo, prev_lo = 0;
        for (int i = 0; i < 8; i++) begin
            get_pulse(1, hb, lo);
            if (i == 0) begin
                if (hb != first_hb) timing_ok = 1'b0;
            end else if (hb + prev_lo != 10 * CPT) begin
                timing_ok = 1'b0;
            end
            if (lo == cell_low(1'b1)) got[i] = 1'b1;
            else if (lo != cell_low(1'b0)) timing_ok = 1'b0;
            prev_lo = lo;
        end
        last_lo = prev_lo;
        check(got == exp, {"R4 ", tag, " byte value LSB first"}, got, exp);
        check(timing_ok, {"R4 ", tag, " cell timing"}, timing_ok, 1);
    endtask

    task automatic start_txn(input logic [7:0] c, input logic [7:0] d, output int last_lo);
        int hb, lo;
        cmd = c;
        txd = d;
        req = req + 8'd1;
        get_pulse(0, hb, lo);
        check(hb == 0, "R2 start on next edge", hb, 0);
        check(lo == 10 * CPT, "R1 R3 break width", lo, 10 * CPT);
        take_byte(c, 3 * CPT, last_lo, "R3 R5 command");
    endtask

    task automatic wait_done(input int limit);
        int n = 0;
        while (done_cnt != req && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic do_write(input logic [7:0] c, input logic [7:0] d);
        int last_lo;
        start_txn(c, d, last_lo);
        // change inputs mid-transaction: the latched values must be used
        txd = ~d;
        take_byte(d, 10 * CPT - last_lo + 15 * CPT, last_lo, "R6 write data");
        wait_done(40 * CPT);
        check(done_cnt == req, "R2 write completion count", done_cnt, req);
        check(err_code == 2'd0, "R6 write result code", err_code, 0);
        check(!line_oe, "R11 released in idle", line_oe, 0);
    endtask

    task automatic drive_bit(input logic b, input int high_ticks);
        int lt = b ? $urandom_range(2, 1) : $urandom_range(7, 5);
        pull = 1'b1;
        repeat (lt * CPT) @(negedge clk);
        pull = 1'b0;
        repeat (high_ticks * CPT) @(negedge clk);
    endtask

    // mode 0 normal, 1 silent, 2 first low stuck, 3 high stuck after a bit,
    // 4 low stuck on second bit
    task automatic do_read(input logic [7:0] c, input logic [7:0] dv, input int mode);
        int last_lo;
        int exp_err;
        start_txn(c, 8'h00, last_lo);
        dev_active = 1'b1;
        oe_bad = 1'b0;
        repeat (12 * CPT) @(negedge clk);
        case (mode)
            0: for (int i = 0; i < 8; i++) drive_bit(dv[i], $urandom_range(6, 2));
            2: begin pull = 1'b1; repeat (40 * CPT) @(negedge clk); end
            3: drive_bit(1'b1, 60);
            4: begin drive_bit(1'b0, 3); pull = 1'b1; repeat (40 * CPT) @(negedge clk); end
            default: ;
        endcase
        wait_done(400 * CPT);
        pull = 1'b0;
        exp_err = (mode == 4) ? 2 : mode;
        check(done_cnt == req, "R2 read completion count", done_cnt, req);
        check(err_code == 2'(exp_err), "R7 R9 R10 read result code", err_code, exp_err);
        if (mode == 0) begin
            check(rx_data == dv, "R8 received byte", rx_data, dv);
            last_rx = dv;
        end else begin
            check(rx_data == last_rx, "R11 rx held on error", rx_data, last_rx);
        end
        check(!oe_bad, "R7 no drive while receiving", oe_bad, 0);
        dev_active = 1'b0;
        repeat (4 * CPT) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        check(line_oe == 1'b0, "R11 reset line released", line_oe, 0);
        check(done_cnt == 8'd0, "R2 reset completion count", done_cnt, 0);
        check(err_code == 2'd0, "R11 reset result code", err_code, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(line_oe == 1'b0, "R2 no start while counters equal", line_oe, 0);

        // directed corners
        do_write(8'hFF, 8'h00);
        do_write(8'h80, 8'hFF);
        do_read(8'h00, 8'hFF, 0);
        do_read(8'h7F, 8'h00, 0);
        do_read(8'h12, 8'hA5, 1);
        do_read(8'h34, 8'h00, 2);
        do_read(8'h56, 8'h00, 3);
        do_read(8'h21, 8'h00, 4);

        // randomized mix
        for (int k = 0; k < 16; k++) begin
            logic [7:0] c = 8'($urandom());
            logic [7:0] d = 8'($urandom());
            if (c[7]) do_write(c, d);
            else do_read(c, d, 0);
        end
        finish_run();
    end
endmodule